// File: doc/BRIEF.md
# Single-Word Arithmetic Shift Unit

This unit shifts a 36-bit two's-complement word by a signed amount and registers the result. The amount arrives as an 18-bit address-style field. Its top bit picks the direction, and its low eight bits give the distance, either directly or after negation. The sign bit never moves. A left shift slides only the 35 magnitude bits and fills the vacated low end with zeros. A right shift copies the sign into the vacated high end.

The unit also raises an overflow pulse and a trap pulse in the same cycle as the result. These pulses appear whenever a left shift pushes out a bit that disagrees with the sign. A surrounding flag register is expected to OR the pulses in, because the unit keeps no flag state of its own. The result appears one clock after the operand and field are presented, and a new pair may be presented every cycle.

Top module: `ash_unit`

## Requirements
- R1: When field bit 17 is 0 the operand shifts left. When field bit 17 is 1 it shifts right.
- R2: A left distance is field bits 7..0, and bits 16..8 are ignored. A right distance is bits 7..0 of the 18-bit two's-complement negation of the field. For example, field 3FFF7 hex shifts right by 9, and field 20000 hex shifts right by 0.
- R3: A left shift keeps result bit 35 equal to operand bit 35 and fills vacated low bits with zeros. For example, octal 000111222333 shifted left by 6 gives 011122233300, and octal 777555333111 shifted left by 6 gives 755533311100.
- R4: On a left shift, overflow and trap are both 1 when any bit leaving bit position 34 differs from the sign. Otherwise both are 0.
- R5: A left distance of 35 or more gives 0 for a non-negative operand and octal 400000000000 for a negative one. The flags are 1 when any operand bit 34..0 differs from the sign.
- R6: A right shift fills with the sign. For example, octal 000111222333 shifted right by 9 gives 000000111222, and 777555333111 gives 777777555333. A distance of 35 or more gives 0 or all ones, depending on the sign.
- R7: A right shift never raises overflow or trap.
- R8: A distance of 0 in either direction returns the operand unchanged with both flags 0.
- R9: Outputs change one clock after their inputs. While the synchronous reset is high at a clock edge, the result and both flags become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_operand | input | 36 | Word to shift |
| i_field | input | 18 | Signed shift field: bit 17 is the direction, bits 7..0 are the distance |
| o_result | output | 36 | Registered shifted word |
| o_overflow | output | 1 | Registered overflow pulse |
| o_trap | output | 1 | Registered trap pulse |

## Verification
Two functions meet in a single cycle on a saturating left shift: the sign-only result and the overflow/trap detection. The bench provokes this with distances of exactly 35 and far beyond it, using operands whose magnitude bits either all match the sign or contain a single disagreeing bit. A bit-serial reference model computes the expected result and flags together, and the two are judged in one comparison. The model shifts one position per step and notes each bit that leaves position 34.

// File: rtl/ash_pkg.sv
package ash_pkg;
  localparam int DEF_WORD_W  = 36;
  localparam int DEF_FIELD_W = 18;
  localparam int DEF_CNT_W   = 8;
endpackage

// File: rtl/ash_count_decode.sv
module ash_count_decode #(
  parameter int FIELD_W = 18,
  parameter int CNT_W   = 8
) (
  input  logic [FIELD_W-1:0] field,
  output logic               dir_right,
  output logic [CNT_W-1:0]   cnt
);
  logic [FIELD_W-1:0] negated;

  always_comb begin
    negated   = ~field + {{(FIELD_W-1){1'b0}}, 1'b1};
    dir_right = field[FIELD_W-1];
    cnt       = dir_right ? negated[CNT_W-1:0] : field[CNT_W-1:0];
  end
endmodule

// File: rtl/ash_left_path.sv
module ash_left_path #(
  parameter int W     = 36,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     op,
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     res,
  output logic             lost
);
  localparam int MW = W - 1;

  logic          sgn;
  logic [MW-1:0] mag, keep_mask, diff;

  always_comb begin
    sgn       = op[W-1];
    mag       = op[MW-1:0];
    keep_mask = {MW{1'b1}} >> cnt;   // bits that survive the shift
    diff      = mag ^ {MW{sgn}};
    lost      = |(diff & ~keep_mask);
    res       = {sgn, mag << cnt};
  end
endmodule

// File: rtl/ash_right_path.sv
module ash_right_path #(
  parameter int W     = 36,
  parameter int CNT_W = 8
) (
  input  logic [W-1:0]     op,
  input  logic [CNT_W-1:0] cnt,
  output logic [W-1:0]     res
);
  always_comb res = $unsigned($signed(op) >>> cnt);
endmodule

// File: rtl/ash_unit.sv
module ash_unit
  import ash_pkg::*;
#(
  parameter int W       = DEF_WORD_W,
  parameter int FIELD_W = DEF_FIELD_W,
  parameter int CNT_W   = DEF_CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       i_operand,
  input  logic [FIELD_W-1:0] i_field,
  output logic [W-1:0]       o_result,
  output logic               o_overflow,
  output logic               o_trap
);
  localparam int SAT = W - 1;

  logic             dir_right, left_lost;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     left_res, right_res;

  ash_count_decode #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_dec (
    .field(i_field), .dir_right(dir_right), .cnt(cnt));

  ash_left_path #(.W(W), .CNT_W(CNT_W)) u_left (
    .op(i_operand), .cnt(cnt), .res(left_res), .lost(left_lost));

  ash_right_path #(.W(W), .CNT_W(CNT_W)) u_right (
    .op(i_operand), .cnt(cnt), .res(right_res));

  always_ff @(posedge clk) begin
    if (rst) begin
      o_result   <= '0;
      o_overflow <= 1'b0;
      o_trap     <= 1'b0;
    end else begin
      o_result   <= dir_right ? right_res : left_res;
      o_overflow <= !dir_right && left_lost;
      o_trap     <= !dir_right && left_lost;
    end
  end

  // R9: reset clears all outputs
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (o_result == '0 && !o_overflow && !o_trap));

  // R3: left shift keeps the sign bit
  p_sign_kept_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(i_field[FIELD_W-1]))
      |-> o_result[W-1] == $past(i_operand[W-1]));

  // R7: right shifts are flag-free
  p_right_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(i_field[FIELD_W-1])) |-> (!o_overflow && !o_trap));

  // R6: saturated right shift is pure sign
  p_right_sat_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(dir_right) && ($past(cnt) >= CNT_W'(SAT)))
      |-> o_result == {W{$past(i_operand[W-1])}});

  // R8: zero distance passes through
  p_zero_pass_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cnt) == '0)
      |-> (o_result == $past(i_operand) && !o_overflow));

  // R4: both flags move together
  p_flag_pair_r4: assert property (@(posedge clk) disable iff (rst)
    o_overflow == o_trap);
endmodule

// File: tb/test_ash_unit.sv
module test_ash_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [35:0] i_operand = '0;
  logic [17:0] i_field = '0;
  logic [35:0] o_result;
  logic        o_overflow, o_trap;

  typedef struct {
    logic [35:0] res;
    logic        ov;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  ash_unit i_ash_unit (
    .clk(clk), .rst(rst), .i_operand(i_operand), .i_field(i_field),
    .o_result(o_result), .o_overflow(o_overflow), .o_trap(o_trap));

  // bit-serial reference model
  function automatic void model(input logic [35:0] op, input logic [17:0] f,
                                output logic [35:0] r, output logic ov);
    logic [17:0] n;
    int c;
    n = ~f + 18'd1;
    c = f[17] ? int'(n[7:0]) : int'(f[7:0]);
    r = op;
    ov = 1'b0;
    for (int i = 0; i < c; i++) begin
      if (f[17]) r = {r[35], r[35:1]};
      else begin
        if (r[34] != r[35]) ov = 1'b1;
        r = {r[35], r[33:0], 1'b0};
      end
    end
  endfunction

  task automatic drive(input logic [35:0] op, input logic [17:0] f, input string tag);
    item_t it;
    model(op, f, it.res, it.ov);
    it.tag = tag;
    @(negedge clk);
    i_operand = op;
    i_field = f;
    q.push_back(it);
  endtask

  task automatic drive_exp(input logic [35:0] op, input logic [17:0] f,
                           input logic [35:0] er, input logic eov, input string tag);
    item_t it;
    it.res = er; it.ov = eov; it.tag = tag;
    @(negedge clk);
    i_operand = op;
    i_field = f;
    q.push_back(it);
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (o_result !== it.res || o_overflow !== it.ov || o_trap !== it.ov) begin
        n_bad++;
        $display("FAIL %s: got %o ov=%b tr=%b, expected %o flags=%b",
                 it.tag, o_result, o_overflow, o_trap, it.res, it.ov);
      end
    end
  end

  task automatic check_reset(input string tag);
    n_chk++;
    if (o_result !== '0 || o_overflow !== 1'b0 || o_trap !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: got %o ov=%b tr=%b, expected 0 flags=0",
               tag, o_result, o_overflow, o_trap);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_reset("R9 reset state");
    rst = 1'b0;
    // R3 / R6 known vectors
    drive_exp(36'o000111222333, 18'd6,      36'o011122233300, 0, "R3 pos left 6");
    drive_exp(36'o000111222333, 18'h3FFF7,  36'o000000111222, 0, "R6 pos right 9");
    drive_exp(36'o777555333111, 18'd6,      36'o755533311100, 0, "R3 neg left 6");
    drive_exp(36'o777555333111, 18'h3FFF7,  36'o777777555333, 0, "R6 neg right 9");
    // R1 / R2 decode
    drive_exp(36'o000000000001, 18'h00105,  36'o000000000040, 0, "R2 high bits ignored");
    drive_exp(36'o000000000400, 18'h3FFFD,  36'o000000000040, 0, "R1 right by 3");
    drive_exp(36'o123456701234, 18'h20000,  36'o123456701234, 0, "R2 R8 right zero");
    drive_exp(36'o723456701234, 18'h00000,  36'o723456701234, 0, "R8 left zero");
    // R4 overflow
    drive_exp(36'o200000000000, 18'd1,      36'o000000000000, 1, "R4 pos loss");
    drive_exp(36'o600000000000, 18'd1,      36'o400000000000, 0, "R4 neg no loss");
    drive_exp(36'o400000000000, 18'd1,      36'o400000000000, 1, "R4 neg loss");
    // R5 saturation with flags in same cycle
    drive_exp(36'o000000000001, 18'd35,     36'o000000000000, 1, "R5 sat pos loss");
    drive_exp(36'o000000000000, 18'd200,    36'o000000000000, 0, "R5 sat zero");
    drive_exp(36'o777777777777, 18'd35,     36'o400000000000, 0, "R5 sat neg clean");
    drive_exp(36'o777777777776, 18'd255,    36'o400000000000, 1, "R5 sat neg loss");
    // R6 / R7 right saturation
    drive_exp(36'o400000000000, 18'h3FFDD,  36'o777777777777, 0, "R6 R7 right 35 neg");
    drive_exp(36'o377777777777, 18'h3FFD8,  36'o000000000000, 0, "R6 R7 right 40 pos");
    // random sweep
    for (int k = 0; k < 300; k++) begin
      logic [35:0] op;
      logic [17:0] f;
      op = {$urandom(), $urandom()};
      f = 18'($urandom());
      if (k % 3 == 0) f[7:0] = 8'($urandom_range(0, 40));
      drive(op, f, f[17] ? "R6 R7 random right" : "R3 R4 R5 random left");
    end
    @(negedge clk);
    i_operand = 36'o777777777777;
    i_field = 18'd3;
    rst = 1'b1;
    @(negedge clk);
    check_reset("R9 mid-run reset");
    rst = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule